// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a 32-bit interval timer with a level interrupt output, reached through a simple word-addressed register port. The port has a byte address, a write strobe, write data and combinational read data. Software programs three things: an expiry value, a clock divider, and a control word with run, interrupt-enable and mode bits. It then starts the timer and either polls the live count or waits for the interrupt.

While the timer runs, a prescaler turns every `div` input clocks into one count tick. Each tick advances the count. On the tick that brings the count up to the expiry value, the block latches a pending flag. It then does one of two things. In auto-reload mode it restarts from zero and keeps generating periodic events. In one-shot mode it parks the count at the expiry value and clears its own run bit. The interrupt line is the pending flag gated by the interrupt enable. Software acknowledges the interrupt by writing one to the pending bit.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control, expiry-value and count registers all read 0, and `irq_o` is low.
- R2: Word offsets select the registers: 0x0 is control, 0x4 is expiry value and 0x8 is the live count. Control bit 0 is run, bit 1 is interrupt enable, bit 2 is pending and bit 3 is mode (1 = auto-reload, 0 = one-shot). Bits 31:8 hold the 24-bit divider, and bits 7:4 read as 0. Writes to the count register are ignored.
- R3: While run is set, the count advances by one every `div` clocks. A divider of 0 behaves like a divider of 1. No tick occurs while run is clear.
- R4: The tick that takes the count to the expiry value sets pending at that clock edge. If the expiry value is 0, the first tick expires.
- R5: In auto-reload mode the count returns to 0 on expiry and keeps running, so pending rises every `value*div` clocks. With div = 50 and value = 100 the period is 5000 clocks, which is 100 µs at 50 MHz.
- R6: In one-shot mode the count holds at the expiry value after expiry and the run bit reads 0.
- R7: Writing 1 to control bit 2 clears pending, and writing 0 there leaves it unchanged. If an expiry and a clearing write land on the same edge, pending stays set.
- R8: `irq_o` is a level equal to pending AND interrupt enable.
- R9: Clearing run freezes both the count and the prescaler phase. Setting run again resumes from the frozen count and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address; bits 3:2 select the word |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the clock edge that samples `we_i`, and read data follows `addr_i` in the same cycle. Once run is set at edge 0, the count equals floor(n/div) after n further edges. Pending and the reload or park happen at edge value*div, and `irq_o` follows pending with no added delay. The bench counts every edge it waits from the enabling write. Each of its bus writes uses exactly one edge. It samples at falling edges on the exact edge where a value is due, and it also checks the edge just before, so an off-by-one in the prescaler, the compare or the reload is caught.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned WORD_CTRL  = 0;
   localparam int unsigned WORD_VALUE = 1;
   localparam int unsigned WORD_COUNT = 2;

   // control word bit positions
   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_IE   = 1;
   localparam int unsigned CB_PEND = 2;
   localparam int unsigned CB_MODE = 3;
   localparam int unsigned CB_DIV  = 8;

   typedef struct packed {
      logic auto_rl;
      logic pend;
      logic ie;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int unsigned DIV_W         = 24,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (HAS_PRESCALER) begin : g_div
         logic [DIV_W-1:0] phase_q;
         logic [DIV_W-1:0] limit;

         // divider 0 behaves as 1
         assign limit  = (div_i == '0) ? '0 : div_i - DIV_W'(1);
         assign tick_o = run_i && (phase_q >= limit);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               phase_q <= '0;
            end else if (run_i) begin
               phase_q <= tick_o ? '0 : phase_q + DIV_W'(1);
            end
         end
      end else begin : g_bypass
         logic unused_div;
         assign unused_div = ^div_i;
         assign tick_o     = run_i;
      end
   endgenerate
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              auto_i,
   input  logic [DATA_W-1:0] value_i,
   output logic              expire_o,
   output logic [DATA_W-1:0] count_o
);
   logic [DATA_W-1:0] count_q;
   logic [DATA_W:0]   nxt;

   assign nxt      = {1'b0, count_q} + (DATA_W+1)'(1);
   assign expire_o = tick_i && (nxt >= {1'b0, value_i});
   assign count_o  = count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (tick_i) begin
         if (expire_o) begin
            count_q <= auto_i ? '0 : value_i;
         end else begin
            count_q <= nxt[DATA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned DIV_W         = 24,
   parameter int unsigned ADDR_W        = 4,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   input  logic [DATA_W-1:0] count_i,
   output ctrl_t             ctrl_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [DATA_W-1:0] value_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] widx;
   logic              wr_ctrl, wr_value;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] value_q;
   logic              unused_bits;

   assign widx        = addr_i[ADDR_W-1:2];
   assign wr_ctrl     = we_i && (widx == WIDX_W'(WORD_CTRL));
   assign wr_value    = we_i && (widx == WIDX_W'(WORD_VALUE));
   assign unused_bits = ^{addr_i[1:0], wdata_i[7:4]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         value_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run     <= wdata_i[CB_RUN];
            ctrl_q.ie      <= wdata_i[CB_IE];
            ctrl_q.auto_rl <= wdata_i[CB_MODE];
         end
         // one-shot expiry stops the timer, overriding a same-edge write
         if (expire_i && !ctrl_q.auto_rl) begin
            ctrl_q.run <= 1'b0;
         end
         // set beats write-one-to-clear
         if (expire_i) begin
            ctrl_q.pend <= 1'b1;
         end else if (wr_ctrl && wdata_i[CB_PEND]) begin
            ctrl_q.pend <= 1'b0;
         end
         if (wr_value) begin
            value_q <= wdata_i;
         end
      end
   end

   generate
      if (HAS_PRESCALER) begin : g_div_reg
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               div_q <= '0;
            end else if (wr_ctrl) begin
               div_q <= wdata_i[CB_DIV +: DIV_W];
            end
         end
         assign div_o = div_q;
      end else begin : g_no_div
         assign div_o = '0;
      end
   endgenerate

   assign ctrl_o  = ctrl_q;
   assign value_o = value_q;

   always_comb begin
      rdata_o = '0;
      case (widx)
         WIDX_W'(WORD_CTRL): begin
            rdata_o[CB_RUN]          = ctrl_q.run;
            rdata_o[CB_IE]           = ctrl_q.ie;
            rdata_o[CB_PEND]         = ctrl_q.pend;
            rdata_o[CB_MODE]         = ctrl_q.auto_rl;
            rdata_o[CB_DIV +: DIV_W] = div_o;
         end
         WIDX_W'(WORD_VALUE): rdata_o = value_q;
         WIDX_W'(WORD_COUNT): rdata_o = count_i;
         default:             rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned DIV_W         = 24,
   parameter int unsigned ADDR_W        = 4,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   generate
      if (ADDR_W < 4) begin : g_chk_addr
         $error("ptmr_top: ADDR_W must be at least 4");
      end
      if (DIV_W < 1 || CB_DIV + DIV_W > DATA_W) begin : g_chk_div
         $error("ptmr_top: divider field does not fit the data word");
      end
   endgenerate

   ctrl_t             ctrl_w;
   logic [DIV_W-1:0]  div_w;
   logic [DATA_W-1:0] value_w;
   logic [DATA_W-1:0] count_w;
   logic              tick_w;
   logic              expire_w;

   ptmr_regs #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .HAS_PRESCALER(HAS_PRESCALER)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
      .expire_i(expire_w), .count_i(count_w), .ctrl_o(ctrl_w), .div_o(div_w),
      .value_o(value_w), .rdata_o(rdata_o)
   );

   ptmr_prescaler #(.DIV_W(DIV_W), .HAS_PRESCALER(HAS_PRESCALER)) u_presc (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl_w.run), .div_i(div_w), .tick_o(tick_w)
   );

   ptmr_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .auto_i(ctrl_w.auto_rl),
      .value_i(value_w), .expire_o(expire_w), .count_o(count_w)
   );

   assign irq_o = ctrl_w.pend & ctrl_w.ie;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] addr_i,
   input logic              we_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              tick_i,
   input logic              expire_i,
   input logic              run_i,
   input logic              auto_i,
   input logic              pend_i,
   input logic [DATA_W-1:0] count_i
);
   logic clr_req;
   assign clr_req = we_i && (addr_i[ADDR_W-1:2] == '0) && wdata_i[2];

   a_r3_tick_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |-> run_i);
   a_r4_expire_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i |=> pend_i);
   a_r5_reload_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i && auto_i) |=> (count_i == '0));
   a_r6_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i && !auto_i) |=> !run_i);
   a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i && clr_req) |=> pend_i);
   a_r9_frozen_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> $stable(count_i));
endmodule

bind ptmr_top ptmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
   .tick_i(tick_w), .expire_i(expire_w), .run_i(ctrl_w.run), .auto_i(ctrl_w.auto_rl),
   .pend_i(ctrl_w.pend), .count_i(count_w)
);

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [3:0] A_CTRL = 4'h0, A_VAL = 4'h4, A_CNT = 4'h8;

   always #2.5 clk = ~clk;

   ptmr_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] cw(int div, bit mode, bit pend, bit ie, bit run);
      return {div[23:0], 4'b0, mode, pend, ie, run};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      we = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one edge per write; returns at the falling edge after the write edge
   task automatic wr(logic [3:0] a, logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic wait_edges(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd(A_VAL, v);  chk("R1 value", v, 0);
      rd(A_CNT, v);  chk("R1 count", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 32'h0001_2345);
      rd(A_VAL, v); chk("R2 value readback", v, 32'h0001_2345);
      wr(A_CTRL, cw(7, 1, 0, 1, 0) | 32'hF0);
      rd(A_CTRL, v); chk("R2 ctrl layout", v, cw(7, 1, 0, 1, 0));
      wr(A_CNT, 32'hFF);
      rd(A_CNT, v); chk("R2 count write ignored", v, 0);
   endtask

   task automatic t_prescale();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 1000);
      wr(A_CTRL, cw(3, 1, 0, 0, 1));
      wait_edges(8);  rd(A_CNT, v); chk("R3 div3 at 8", v, 2);
      wait_edges(1);  rd(A_CNT, v); chk("R3 div3 at 9", v, 3);
      do_reset();
      wr(A_VAL, 1000);
      wr(A_CTRL, cw(0, 1, 0, 0, 1));
      wait_edges(5);  rd(A_CNT, v); chk("R3 div0 as 1", v, 5);
   endtask

   task automatic t_auto();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 4);
      wr(A_CTRL, cw(2, 1, 0, 1, 1));
      wait_edges(7);
      rd(A_CTRL, v); chk("R4 no pend before", {31'b0, v[2]}, 0);
      chk("R8 irq low before", {31'b0, irq}, 0);
      wait_edges(1);
      rd(A_CTRL, v); chk("R4 pend at expiry", {31'b0, v[2]}, 1);
      rd(A_CNT, v);  chk("R5 reload to 0", v, 0);
      chk("R8 irq high", {31'b0, irq}, 1);
      wr(A_CTRL, cw(2, 1, 1, 1, 1));       // edge 9: clear
      rd(A_CTRL, v); chk("R7 w1c clears", {31'b0, v[2]}, 0);
      chk("R8 irq follows clear", {31'b0, irq}, 0);
      wait_edges(6);
      rd(A_CTRL, v); chk("R5 no pend at 15", {31'b0, v[2]}, 0);
      wait_edges(1);
      rd(A_CTRL, v); chk("R5 second expiry", {31'b0, v[2]}, 1);
      wr(A_CTRL, cw(2, 1, 0, 1, 1));       // write 0 to pend
      rd(A_CTRL, v); chk("R7 w0 keeps pend", {31'b0, v[2]}, 1);
   endtask

   task automatic t_period();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 100);
      wr(A_CTRL, cw(50, 1, 0, 1, 1));
      wait_edges(4999); chk("R5 period not yet", {31'b0, irq}, 0);
      wait_edges(1);    chk("R5 period 5000", {31'b0, irq}, 1);
      wr(A_CTRL, cw(50, 1, 1, 1, 1));
      wait_edges(4998); chk("R5 repeat not yet", {31'b0, irq}, 0);
      wait_edges(1);    chk("R5 repeat 10000", {31'b0, irq}, 1);
      rd(A_CNT, v);     chk("R5 count after repeat", v, 0);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 3);
      wr(A_CTRL, cw(1, 0, 0, 0, 1));
      wait_edges(3);
      rd(A_CTRL, v); chk("R6 run cleared, pend set", v, cw(1, 0, 1, 0, 0));
      chk("R8 irq masked", {31'b0, irq}, 0);
      wait_edges(5);
      rd(A_CNT, v);  chk("R6 count held", v, 3);
      wr(A_CTRL, cw(1, 0, 0, 1, 0));
      chk("R8 irq on enable", {31'b0, irq}, 1);
      do_reset();
      wr(A_VAL, 0);
      wr(A_CTRL, cw(4, 0, 0, 0, 1));
      wait_edges(3);
      rd(A_CTRL, v); chk("R4 value0 not yet", {31'b0, v[2]}, 0);
      wait_edges(1);
      rd(A_CTRL, v); chk("R4 value0 first tick", {31'b0, v[2]}, 1);
      rd(A_CNT, v);  chk("R4 value0 count", v, 0);
   endtask

   task automatic t_freeze();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 100);
      wr(A_CTRL, cw(4, 1, 0, 0, 1));
      wait_edges(6);
      wr(A_CTRL, cw(4, 1, 0, 0, 0));       // edge 7, phase now 3
      wait_edges(10);
      rd(A_CNT, v);  chk("R9 frozen count", v, 1);
      wr(A_CTRL, cw(4, 1, 0, 0, 1));
      rd(A_CNT, v);  chk("R9 resume value", v, 1);
      wait_edges(1);
      rd(A_CNT, v);  chk("R9 phase kept", v, 2);
   endtask

   task automatic t_setwins();
      logic [31:0] v;
      do_reset();
      wr(A_VAL, 5);
      wr(A_CTRL, cw(1, 1, 0, 0, 1));
      wait_edges(4);
      wr(A_CTRL, cw(1, 1, 1, 0, 1));       // lands on expiry edge 5
      rd(A_CTRL, v); chk("R7 set wins", {31'b0, v[2]}, 1);
      rd(A_CNT, v);  chk("R7 reload same edge", v, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_regmap();
      t_prescale();
      t_auto();
      t_period();
      t_oneshot();
      t_freeze();
      t_setwins();
      finish_run();
   end
endmodule